// File: doc/BRIEF.md
# Crystal Startup Timer and Clock Frequency Meter

This block brings a crystal oscillator up and then measures its frequency. Software loads an 8-bit startup count and raises an enable. The block drives the oscillator enable pin and waits on the slow reference clock for eight slow cycles per unit of that count. It then reports the oscillator as stable. Next, a gate sixteen slow cycles wide is opened, and the number of main-clock rising edges that fall inside it is counted.

Three clocks are involved: a bus clock for the register side, the slow reference clock for timing, and the main (oscillator) clock for counting. The gate crosses into the main domain through a two-flop synchronizer. The 16-bit result is captured in a holding register and handed to the bus domain by a request/acknowledge exchange, so the published count is never a mix of old and new bits. The result is a status value, not a stream. It has no back-pressure and stays published until the enable is dropped.

Top module: `osc_meter`

## Requirements
- R1: After reset, osc_stable, meas_ready and meas_count are 0, and osc_drive follows osc_en at all times.
- R2: Call the first slow_clk rising edge after a startup-count write or a rise of osc_en edge 1. For a count N (N of at least 1), osc_stable is still 0 shortly after edge 8N+2 and is 1 shortly after edge 8N+3. The timer itself runs exactly 8N slow cycles from its load on edge 3.
- R3: The gate is open for exactly 16 slow cycles. meas_count equals the number of main_clk rising edges inside it: 128 when main_clk is 8 times the slow frequency, 160 when it is 10 times.
- R4: meas_ready rises only once the count has reached the bus domain. Until then meas_count reads 0. Afterwards meas_count holds its value.
- R5: A startup-count write while the countdown runs restarts the countdown with the new value. This holds even when the reload lands on the same slow edge on which the old countdown would have expired: the reload wins, and osc_stable stays 0.
- R6: A startup-count write after osc_stable is set does not change osc_stable, meas_ready or meas_count. The new value applies from the next enable.
- R7: Dropping osc_en clears osc_stable, meas_ready and meas_count on the next bus_clk edge, and the main-domain counter is cleared as well.
- R8: Raising osc_en again restarts the countdown with the stored count and runs a fresh measurement.
- R9: The main-domain holding register does not change while its transfer request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| bus_clk | input | 1 | Register-side clock |
| slow_clk | input | 1 | Slow reference clock |
| main_clk | input | 1 | Oscillator clock being measured |
| osc_en | input | 1 | Software enable for the oscillator |
| cfg_wr | input | 1 | Write strobe for the startup count (bus_clk) |
| cfg_startup | input | 8 | Startup count, in units of 8 slow cycles |
| osc_drive | output | 1 | Enable to the analog oscillator |
| osc_stable | output | 1 | Oscillator stable status |
| meas_ready | output | 1 | Measurement result valid |
| meas_count | output | 16 | Main-clock cycles counted in the window |

## Verification
Two slow-domain events can fall on the same edge: expiry of the countdown and a reload from a startup-count write. The bench provokes this by enabling with a count of 2 and then issuing a fresh write sixteen slow edges later. The write's synchronized load then lands on exactly the edge where the first countdown ends. The test passes only if osc_stable stays low through that edge and rises at the time the second count sets, and if the measurement that follows still gives the exact edge count.

// File: rtl/osc_meter_pkg.sv
package osc_meter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_MEAS  = 2'd2,
    ST_DONE  = 2'd3
  } osc_state_e;
endpackage

// File: rtl/osc_sync2.sv
module osc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic ff1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1 <= 1'b0;
      q   <= 1'b0;
    end else begin
      ff1 <= d_async;
      q   <= ff1;
    end
  end
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
  import osc_meter_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int WIN_CYC = 16
) (
  input  logic             slow_clk,
  input  logic             rst_n,
  input  logic             en_async,
  input  logic             wtog_async,
  input  logic [CNT_W-1:0] startup,
  output logic             stable_o,
  output logic             gate_o
);
  localparam int DLY_W = CNT_W + 3;
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic en_s, wtog_s, en_prev, wtog_prev;
  logic en_rise, wr_evt;
  osc_state_e       st_q;
  logic [DLY_W-1:0] remain_q;
  logic [WIN_W-1:0] win_q;
  logic             stable_q, gate_q;

  osc_sync2 u_sync_en (.clk(slow_clk), .rst_n(rst_n), .d_async(en_async),   .q(en_s));
  osc_sync2 u_sync_wr (.clk(slow_clk), .rst_n(rst_n), .d_async(wtog_async), .q(wtog_s));

  assign en_rise = en_s & ~en_prev;
  assign wr_evt  = wtog_s ^ wtog_prev;

  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev   <= 1'b0;
      wtog_prev <= 1'b0;
      st_q      <= ST_IDLE;
      remain_q  <= '0;
      win_q     <= '0;
      stable_q  <= 1'b0;
      gate_q    <= 1'b0;
    end else begin
      en_prev   <= en_s;
      wtog_prev <= wtog_s;
      if (!en_s) begin
        st_q     <= ST_IDLE;
        stable_q <= 1'b0;
        gate_q   <= 1'b0;
        win_q    <= '0;
      end else if (en_rise || (wr_evt && st_q == ST_COUNT)) begin
        // reload has priority over an expiry on the same edge
        st_q     <= ST_COUNT;
        remain_q <= {startup, 3'b000};
        stable_q <= 1'b0;
        gate_q   <= 1'b0;
        win_q    <= '0;
      end else begin
        case (st_q)
          ST_COUNT: begin
            if (remain_q <= DLY_W'(1)) begin
              stable_q <= 1'b1;
              gate_q   <= 1'b1;
              win_q    <= '0;
              st_q     <= ST_MEAS;
            end else begin
              remain_q <= remain_q - DLY_W'(1);
            end
          end
          ST_MEAS: begin
            if (win_q == WIN_W'(WIN_CYC - 1)) begin
              gate_q <= 1'b0;
              st_q   <= ST_DONE;
            end else begin
              win_q <= win_q + WIN_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign stable_o = stable_q;
  assign gate_o   = gate_q;

  // independent run-length counter for the gate check
  logic [WIN_W:0] gate_run;
  always_ff @(posedge slow_clk or negedge rst_n) begin
    if (!rst_n)      gate_run <= '0;
    else if (gate_q) gate_run <= gate_run + 1'b1;
    else             gate_run <= '0;
  end

  a_r2_stable_after_count: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(stable_q) |-> $past(st_q) == ST_COUNT);

  a_r3_gate_width: assert property (@(posedge slow_clk) disable iff (!rst_n)
    ($fell(gate_q) && $past(en_s)) |-> gate_run == (WIN_W + 1)'(WIN_CYC));

  a_r7_disable_clears: assert property (@(posedge slow_clk) disable iff (!rst_n)
    !en_s |=> (!stable_q && !gate_q));
endmodule

// File: rtl/osc_gate_counter.sv
module osc_gate_counter #(
  parameter int RES_W = 16
) (
  input  logic             main_clk,
  input  logic             rst_n,
  input  logic             en_async,
  input  logic             gate_async,
  input  logic             ack_async,
  output logic             req_o,
  output logic [RES_W-1:0] hold_o
);
  logic en_s, gate_s, ack_s, gate_prev;
  logic [RES_W-1:0] cnt_q, hold_q;
  logic req_q;

  osc_sync2 u_sync_en   (.clk(main_clk), .rst_n(rst_n), .d_async(en_async),   .q(en_s));
  osc_sync2 u_sync_gate (.clk(main_clk), .rst_n(rst_n), .d_async(gate_async), .q(gate_s));
  osc_sync2 u_sync_ack  (.clk(main_clk), .rst_n(rst_n), .d_async(ack_async),  .q(ack_s));

  always_ff @(posedge main_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_prev <= 1'b0;
      cnt_q     <= '0;
      hold_q    <= '0;
      req_q     <= 1'b0;
    end else begin
      gate_prev <= gate_s;
      if (!en_s) begin
        cnt_q  <= '0;
        hold_q <= '0;
        req_q  <= 1'b0;
      end else begin
        if (gate_s && !gate_prev)  cnt_q <= RES_W'(1);
        else if (gate_s)           cnt_q <= cnt_q + RES_W'(1);
        if (!gate_s && gate_prev) begin
          hold_q <= cnt_q;
          req_q  <= 1'b1;
        end else if (ack_s) begin
          req_q <= 1'b0;
        end
      end
    end
  end

  assign req_o  = req_q;
  assign hold_o = hold_q;

  a_r9_hold_stable: assert property (@(posedge main_clk) disable iff (!rst_n)
    (req_q && $past(req_q)) |-> $stable(hold_q));
endmodule

// File: rtl/osc_bus_side.sv
module osc_bus_side #(
  parameter int CNT_W = 8,
  parameter int RES_W = 16
) (
  input  logic             bus_clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_startup,
  input  logic             stable_async,
  input  logic             req_async,
  input  logic [RES_W-1:0] hold_async,
  output logic [CNT_W-1:0] cfg_q,
  output logic             wtog_q,
  output logic             ack_q,
  output logic             stable_q,
  output logic             ready_q,
  output logic [RES_W-1:0] count_q
);
  logic stable_s, req_s, req_prev;

  osc_sync2 u_sync_st  (.clk(bus_clk), .rst_n(rst_n), .d_async(stable_async), .q(stable_s));
  osc_sync2 u_sync_req (.clk(bus_clk), .rst_n(rst_n), .d_async(req_async),    .q(req_s));

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      wtog_q   <= 1'b0;
      req_prev <= 1'b0;
      ack_q    <= 1'b0;
      stable_q <= 1'b0;
      ready_q  <= 1'b0;
      count_q  <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_q  <= cfg_startup;
        wtog_q <= ~wtog_q;
      end
      req_prev <= req_s;
      if (!osc_en) begin
        ack_q    <= 1'b0;
        stable_q <= 1'b0;
        ready_q  <= 1'b0;
        count_q  <= '0;
      end else begin
        stable_q <= stable_s;
        if (req_s && !req_prev) begin
          count_q <= hold_async;
          ready_q <= 1'b1;
          ack_q   <= 1'b1;
        end else if (!req_s) begin
          ack_q <= 1'b0;
        end
      end
    end
  end

  a_r4_ready_after_req: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(req_s));

  a_r7_bus_clear: assert property (@(posedge bus_clk) disable iff (!rst_n)
    !osc_en |=> (!ready_q && !stable_q && count_q == '0));
endmodule

// File: rtl/osc_meter.sv
module osc_meter #(
  parameter int CNT_W   = 8,
  parameter int RES_W   = 16,
  parameter int WIN_CYC = 16
) (
  input  logic             rst_n,
  input  logic             bus_clk,
  input  logic             slow_clk,
  input  logic             main_clk,
  input  logic             osc_en,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_startup,
  output logic             osc_drive,
  output logic             osc_stable,
  output logic             meas_ready,
  output logic [RES_W-1:0] meas_count
);
  logic [CNT_W-1:0] cfg_q;
  logic             wtog, ack, stable_slow, gate, req;
  logic [RES_W-1:0] hold;

  assign osc_drive = osc_en;

  osc_bus_side #(.CNT_W(CNT_W), .RES_W(RES_W)) u_bus (
    .bus_clk(bus_clk), .rst_n(rst_n), .osc_en(osc_en),
    .cfg_wr(cfg_wr), .cfg_startup(cfg_startup),
    .stable_async(stable_slow), .req_async(req), .hold_async(hold),
    .cfg_q(cfg_q), .wtog_q(wtog), .ack_q(ack),
    .stable_q(osc_stable), .ready_q(meas_ready), .count_q(meas_count)
  );

  osc_startup_timer #(.CNT_W(CNT_W), .WIN_CYC(WIN_CYC)) u_timer (
    .slow_clk(slow_clk), .rst_n(rst_n), .en_async(osc_en),
    .wtog_async(wtog), .startup(cfg_q),
    .stable_o(stable_slow), .gate_o(gate)
  );

  osc_gate_counter #(.RES_W(RES_W)) u_cnt (
    .main_clk(main_clk), .rst_n(rst_n), .en_async(osc_en),
    .gate_async(gate), .ack_async(ack),
    .req_o(req), .hold_o(hold)
  );
endmodule

// File: tb/osc_meter_tb.sv
`timescale 1ns/100ps
module osc_meter_tb;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0, slow_clk = 1'b0, main_clk = 1'b0;
  logic osc_en = 1'b0, cfg_wr = 1'b0;
  logic [7:0] cfg_startup = '0;
  logic osc_drive, osc_stable, meas_ready;
  logic [15:0] meas_count;

  int n_chk = 0, n_bad = 0;
  int main_half = 40;
  int unsigned exp_q[$];
  logic rdy_prev = 1'b0;
  bit done = 1'b0;

  osc_meter u_dut (
    .rst_n(rst_n), .bus_clk(bus_clk), .slow_clk(slow_clk), .main_clk(main_clk),
    .osc_en(osc_en), .cfg_wr(cfg_wr), .cfg_startup(cfg_startup),
    .osc_drive(osc_drive), .osc_stable(osc_stable),
    .meas_ready(meas_ready), .meas_count(meas_count)
  );

  always #10 bus_clk = ~bus_clk;
  initial begin #0.5; forever #320 slow_clk = ~slow_clk; end
  initial forever #(main_half) main_clk = ~main_clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge bus_clk) begin
    if (rst_n) begin
      if (meas_ready && !rdy_prev) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected result", int'(meas_count), -1);
        else begin
          int unsigned e;
          e = exp_q.pop_front();
          check(meas_count == 16'(e), "R3 measured count", int'(meas_count), int'(e));
        end
      end
      rdy_prev = meas_ready;
    end
  end

  task automatic align();
    @(posedge slow_clk); #50; @(negedge bus_clk);
  endtask

  task automatic write_cfg(input int n);
    cfg_startup = 8'(n); cfg_wr = 1'b1;
    @(negedge bus_clk); cfg_wr = 1'b0;
  endtask

  task automatic slow_edges(input int n);
    repeat (n) @(posedge slow_clk);
    #100;
  endtask

  // after an aligned action: stable low after edge 8N+2, high after 8N+3
  task automatic check_startup(input int n, input string req);
    slow_edges(8*n + 2);
    check(osc_stable == 1'b0, req, int'(osc_stable), 0);
    slow_edges(1);
    check(osc_stable == 1'b1, req, int'(osc_stable), 1);
  endtask

  task automatic wait_result();
    while (exp_q.size() != 0) @(negedge bus_clk);
    @(negedge bus_clk);
  endtask

  task automatic disable_osc();
    @(negedge bus_clk); osc_en = 1'b0;
    @(negedge bus_clk);
    check(osc_stable == 1'b0, "R7 stable cleared", int'(osc_stable), 0);
    check(meas_ready == 1'b0, "R7 ready cleared", int'(meas_ready), 0);
    check(meas_count == 16'd0, "R7 count cleared", int'(meas_count), 0);
    check(osc_drive == 1'b0, "R1 drive follows enable", int'(osc_drive), 0);
    slow_edges(4);
  endtask

  initial begin
    #3_000_000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge bus_clk);
    check(osc_stable == 1'b0 && meas_ready == 1'b0, "R1 reset status", int'({osc_stable, meas_ready}), 0);
    check(meas_count == 16'd0, "R1 reset count", int'(meas_count), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge bus_clk);

    // R2/R3: count 5, ratio 8
    write_cfg(5);
    align(); osc_en = 1'b1;
    exp_q.push_back(128);
    #1;
    check(osc_drive == 1'b1, "R1 drive follows enable", int'(osc_drive), 1);
    @(negedge bus_clk);
    check(meas_ready == 1'b0 && meas_count == 16'd0, "R4 no result before ready", int'(meas_count), 0);
    check_startup(5, "R2 startup delay N=5");
    wait_result();
    slow_edges(3);
    check(meas_count == 16'd128, "R4 count held", int'(meas_count), 128);

    // R6: write while stable
    align(); write_cfg(3);
    slow_edges(6);
    check(osc_stable == 1'b1, "R6 stable unaffected", int'(osc_stable), 1);
    check(meas_ready == 1'b1, "R6 ready unaffected", int'(meas_ready), 1);
    check(meas_count == 16'd128, "R6 count unaffected", int'(meas_count), 128);

    // R7 then R8 with ratio 10, stored count 3
    disable_osc();
    main_half = 32;
    slow_edges(2);
    align(); osc_en = 1'b1;
    exp_q.push_back(160);
    check_startup(3, "R8 re-enable uses stored count");
    wait_result();

    // R5: rewrite mid-countdown
    disable_osc();
    write_cfg(20);
    align(); osc_en = 1'b1;
    slow_edges(30);
    check(osc_stable == 1'b0, "R5 still counting", int'(osc_stable), 0);
    align(); write_cfg(4);
    exp_q.push_back(160);
    check_startup(4, "R5 restart with new count");
    wait_result();

    // R5: reload on the expiry edge
    disable_osc();
    write_cfg(2);
    align(); osc_en = 1'b1;
    repeat (16) @(posedge slow_clk);
    #50; @(negedge bus_clk);
    write_cfg(3);
    exp_q.push_back(160);
    slow_edges(4);
    check(osc_stable == 1'b0, "R5 reload beats expiry", int'(osc_stable), 0);
    slow_edges(22);
    check(osc_stable == 1'b0, "R5 second count pending", int'(osc_stable), 0);
    slow_edges(1);
    check(osc_stable == 1'b1, "R5 second count expires", int'(osc_stable), 1);
    wait_result();

    check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule